// File: doc/BRIEF.md
# Bit-Error-Rate Pattern Checker (Receive Side)

This block is the receiving half of a bit-error-rate tester. It runs a small bus-master sequence against a byte-oriented serial receiver (a UART-style register file). First, it programs the receiver's baud divisor once. Next, it waits for the serial line to stay at its idle (high) level for a programmed span. That span is eight divisor periods, counted one step per clock. After the span it seeds its own 8-bit pattern generator and raises `ready`.

From then on it polls the receiver's status register for a byte. It fetches each byte that arrives and compares it with the byte its own generator expects. It then advances the generator by one byte, which is eight single-bit shifts. Each mismatching byte bumps a small error counter. The counter sticks at its maximum value instead of wrapping, so a broken link shows up as a full count that stays put.

The register bus is a simple master. `bus_addr` selects the register and `bus_wdata` carries write data. The write strobe `bus_wr_n` is active low. `bus_rdata` returns the selected register's contents in the same cycle. The receiver is expected to drop its byte-available flag once its data register has been selected for a cycle. The read strobe `bus_rd` is never used.

Top module: `berx_rx`

## Requirements
- R1: While `rst_n` is low and on release, `ready` is 0, `err_cnt` is 0, `bus_wr_n` is 1 and `bus_addr` is 3'b010.
- R2: After reset the block writes exactly once. `bus_wr_n` is low for a single cycle with `bus_addr` = 3'b010 and `bus_wdata` = DIV_BASE + `div_lsb`, and it stays high from then on.
- R3: The idle counter is loaded with (DIV_BASE + `div_lsb`) × 8 − 1 on the second rising edge after reset. Starting at the third edge, `ready` goes high after (DIV_BASE + `div_lsb`) × 8 consecutive high samples of `rx_line`.
- R4: A low sample of `rx_line` before the count has run out reloads the counter. A full run of (DIV_BASE + `div_lsb`) × 8 high samples is needed again after it.
- R5: Once high, `ready` stays high until reset, whatever `rx_line` does.
- R6: After `ready`, `bus_addr` sits at 3'b001 (status) while bit 3 of `bus_rdata` (mask 8'h08) is 0. When that bit is 1, `bus_addr` becomes 3'b100 (data) for exactly one cycle and then returns to 3'b001.
- R7: The first fetched byte is compared with 8'h01. Before each later compare the generator advances by eight steps. Each step shifts the byte toward the MSB and inserts bit1 ^ bit2 ^ bit3 ^ bit7 of the old value at bit 0.
- R8: A fetched byte that matches the expected byte leaves `err_cnt` unchanged. A mismatch increments it; the new value is visible the cycle after the fetch cycle.
- R9: `err_cnt` saturates at 2^ERR_W − 1 (15 by default). Further mismatches leave it there.
- R10: `bus_rd` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial line level, idle high |
| div_lsb | input | LSB_W | Low part added to the divisor base |
| bus_addr | output | 3 | Register select toward the receiver |
| bus_wdata | output | DATA_W | Write data (divisor value) |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd | output | 1 | Read strobe, held inactive |
| bus_rdata | input | BYTE_W | Contents of the selected register |
| ready | output | 1 | Pattern generator aligned and checking |
| err_cnt | output | ERR_W | Saturating count of mismatching bytes |

## Verification
The bench builds the block with DIV_BASE = 16 and LSB_W = 3. This shrinks the idle window to between 128 and 184 clocks instead of several thousand. With that window, one run can place line glitches early and late in the countdown, and can repeat synchronisation under a second divisor value after a fresh reset. The default 4-bit counter is kept, so a burst of eighteen corrupted bytes drives it through saturation. Matching bytes sent afterwards show that it stays at 15.

// File: rtl/berx_pkg.sv
package berx_pkg;

    typedef enum logic [2:0] {
        ST_DIV_WR  = 3'd0,
        ST_DIV_REL = 3'd1,
        ST_SYNC    = 3'd2,
        ST_POLL    = 3'd3,
        ST_FETCH   = 3'd4
    } berx_state_e;

    localparam logic [2:0] ADDR_DIV  = 3'b010;
    localparam logic [2:0] ADDR_STAT = 3'b001;
    localparam logic [2:0] ADDR_DATA = 3'b100;

    localparam int STAT_RX_BIT = 3;

endpackage

// File: rtl/berx_lfsr.sv
module berx_lfsr #(
    parameter int           W     = 8,
    parameter logic [W-1:0] TAPS  = 8'b1000_1110,
    parameter logic [W-1:0] SEED  = 8'h01,
    parameter int           STEPS = W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] q
);

    logic [W-1:0] pat_d, pat_q;

    function automatic logic [W-1:0] step1(input logic [W-1:0] v);
        return {v[W-2:0], ^(v & TAPS)};
    endfunction

    always_comb begin
        pat_d = pat_q;
        if (load) begin
            pat_d = SEED;
        end else if (adv) begin
            for (int i = 0; i < STEPS; i++) begin
                pat_d = step1(pat_d);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= SEED;
        else        pat_q <= pat_d;
    end

    assign q = pat_q;

    // R7: the generator never falls into the all-zero lock-up state
    assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pat_q != '0);

    // R7: a seed request lands the seed on the next cycle
    assert_lfsr_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pat_q == SEED);

endmodule

// File: rtl/berx_idle_sync.sv
module berx_idle_sync #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic             line,
    input  logic [CNT_W-1:0] reload,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] span;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        done = 1'b0;
        if (load) begin
            sy_d.cnt  = reload;
            sy_d.span = reload;
        end else if (en) begin
            if (!line) begin
                sy_d.cnt = sy_q.span;
            end else if (sy_q.cnt == '0) begin
                done = 1'b1;
            end else begin
                sy_d.cnt = sy_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    // R4: a low sample during the countdown restarts the full span
    assert_glitch_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !line) |=> sy_q.cnt == sy_q.span);

    // R3: each idle sample above zero takes exactly one step off the count
    assert_idle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && line && sy_q.cnt != '0) |=> sy_q.cnt == $past(sy_q.cnt) - 1'b1);

endmodule

// File: rtl/berx_err_tally.sv
module berx_err_tally #(
    parameter int W      = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [BYTE_W-1:0] got,
    input  logic [BYTE_W-1:0] want,
    output logic [W-1:0]      cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] tal_d, tal_q;
    logic         miss;

    always_comb begin
        miss  = valid && (got != want);
        tal_d = tal_q;
        if (miss && tal_q != CNT_MAX) begin
            tal_d = tal_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tal_q <= '0;
        else        tal_q <= tal_d;
    end

    assign cnt = tal_q;

    // R9: once full, the count holds
    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tal_q == CNT_MAX |=> tal_q == CNT_MAX);

    // R8: a matching byte leaves the count alone
    assert_match_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && got == want) |=> $stable(tal_q));

    // R8: a mismatch below the ceiling adds exactly one
    assert_miss_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && got != want && tal_q != CNT_MAX) |=> tal_q == $past(tal_q) + 1'b1);

    // R9: the count never goes down outside reset
    assert_no_decrease_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tal_q >= $past(tal_q));

endmodule

// File: rtl/berx_rx.sv
module berx_rx #(
    parameter int DIV_BASE     = 1024,
    parameter int LSB_W        = 4,
    parameter int DATA_W       = 16,
    parameter int BYTE_W       = 8,
    parameter int ERR_W        = 4,
    parameter int IDLE_PERIODS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [LSB_W-1:0]  div_lsb,
    output logic [2:0]        bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr_n,
    output logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              ready,
    output logic [ERR_W-1:0]  err_cnt
);
    import berx_pkg::*;

    localparam int CNT_W = $clog2((DIV_BASE + (2 ** LSB_W)) * IDLE_PERIODS);

    typedef struct packed {
        berx_state_e       st;
        logic [2:0]        addr;
        logic [DATA_W-1:0] wdata;
        logic              wr_n;
        logic              rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              sync_load, sync_en, sync_done;
    logic              gen_load, gen_adv, chk_valid;
    logic [CNT_W-1:0]  sync_reload;
    logic [BYTE_W-1:0] gen_byte;

    assign sync_reload = (CNT_W'(DIV_BASE) + CNT_W'(div_lsb)) * CNT_W'(IDLE_PERIODS)
                         - CNT_W'(1);

    always_comb begin
        ctl_d     = ctl_q;
        sync_load = 1'b0;
        sync_en   = 1'b0;
        gen_load  = 1'b0;
        gen_adv   = 1'b0;
        chk_valid = 1'b0;
        case (ctl_q.st)
            ST_DIV_WR: begin
                ctl_d.wdata = DATA_W'(DIV_BASE) + DATA_W'(div_lsb);
                ctl_d.wr_n  = 1'b0;
                ctl_d.st    = ST_DIV_REL;
            end
            ST_DIV_REL: begin
                ctl_d.wr_n = 1'b1;
                sync_load  = 1'b1;
                ctl_d.st   = ST_SYNC;
            end
            ST_SYNC: begin
                sync_en = 1'b1;
                if (sync_done) begin
                    gen_load   = 1'b1;
                    ctl_d.addr = ADDR_STAT;
                    ctl_d.rdy  = 1'b1;
                    ctl_d.st   = ST_POLL;
                end
            end
            ST_POLL: begin
                if (bus_rdata[STAT_RX_BIT]) begin
                    ctl_d.addr = ADDR_DATA;
                    ctl_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                chk_valid  = 1'b1;
                gen_adv    = 1'b1;
                ctl_d.addr = ADDR_STAT;
                ctl_d.st   = ST_POLL;
            end
            default: begin
                ctl_d.st = ST_DIV_WR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_DIV_WR;
            ctl_q.addr  <= ADDR_DIV;
            ctl_q.wdata <= '0;
            ctl_q.wr_n  <= 1'b1;
            ctl_q.rdy   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    berx_idle_sync #(
        .CNT_W (CNT_W)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sync_load),
        .en     (sync_en),
        .line   (rx_line),
        .reload (sync_reload),
        .done   (sync_done)
    );

    berx_lfsr #(
        .W (BYTE_W)
    ) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gen_load),
        .adv   (gen_adv),
        .q     (gen_byte)
    );

    berx_err_tally #(
        .W      (ERR_W),
        .BYTE_W (BYTE_W)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (chk_valid),
        .got   (bus_rdata),
        .want  (gen_byte),
        .cnt   (err_cnt)
    );

    assign bus_addr  = ctl_q.addr;
    assign bus_wdata = ctl_q.wdata;
    assign bus_wr_n  = ctl_q.wr_n;
    assign bus_rd    = 1'b0;
    assign ready     = ctl_q.rdy;

    // R2: a write only ever goes to the divisor register
    assert_wr_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_addr == ADDR_DIV);

    // R2: the write strobe is a single-cycle pulse
    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |=> bus_wr_n);

    // R5: ready is sticky
    assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R6: the data register is selected for one cycle, then status again
    assert_fetch_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_DATA |=> bus_addr == ADDR_STAT);

    // R6: without a byte flag the block keeps polling status
    assert_keep_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_addr == ADDR_STAT && !bus_rdata[STAT_RX_BIT]) |=> bus_addr == ADDR_STAT);

    // R1: nothing leaves the divisor address before alignment
    assert_pre_ready_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> bus_addr == ADDR_DIV);

endmodule

// File: tb/test_berx_rx.sv
module test_berx_rx;

    localparam int B  = 16;
    localparam int LW = 3;
    localparam int DW = 16;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_line = 1'b1;
    logic [LW-1:0] div_lsb = 3'd5;
    logic [2:0]    bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wr_n;
    logic          bus_rd;
    logic [7:0]    bus_rdata;
    logic          ready;
    logic [EW-1:0] err_cnt;

    always #10 clk = ~clk;

    berx_rx #(
        .DIV_BASE (B),
        .LSB_W    (LW),
        .DATA_W   (DW),
        .ERR_W    (EW)
    ) i_berx_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .div_lsb   (div_lsb),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr_n  (bus_wr_n),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .ready     (ready),
        .err_cnt   (err_cnt)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Eight-step advance written as explicit per-bit equations
    function automatic logic [7:0] next8(input logic [7:0] r);
        logic [7:0] n;
        n[7] = r[1] ^ r[2] ^ r[3] ^ r[7];
        n[6] = r[0] ^ r[1] ^ r[2] ^ r[6];
        n[5] = r[0] ^ r[2] ^ r[3] ^ r[5] ^ r[7];
        n[4] = r[3] ^ r[4] ^ r[6] ^ r[7];
        n[3] = r[2] ^ r[3] ^ r[5] ^ r[6];
        n[2] = r[1] ^ r[2] ^ r[4] ^ r[5];
        n[1] = r[0] ^ r[1] ^ r[3] ^ r[4];
        n[0] = r[0] ^ r[1] ^ r[7];
        return n;
    endfunction

    // Receiver stub: status at 001 (bit 3 = byte waiting), data at 100
    logic       have = 1'b0;
    logic [7:0] sdata = 8'h00;
    logic       push_req = 1'b0;
    logic [7:0] push_data = 8'h00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   have <= 1'b0;
        else if (bus_addr == 3'b100)  have <= 1'b0;
        else if (push_req) begin
            have  <= 1'b1;
            sdata <= push_data;
        end
    end

    always_comb begin
        case (bus_addr)
            3'b001:  bus_rdata = {4'b0000, have, 3'b000};
            3'b100:  bus_rdata = sdata;
            default: bus_rdata = 8'h00;
        endcase
    end

    // Ready model: sampled line at each edge, run of highs from third edge
    int edge_n = 0;
    int run    = 0;
    bit rdy_m  = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            edge_n = 0; run = 0; rdy_m = 1'b0;
        end else begin
            edge_n++;
            if (edge_n >= 3 && !rdy_m) begin
                if (rx_line) run++;
                else         run = 0;
                if (run == (B + int'(div_lsb)) * 8) rdy_m = 1'b1;
            end
        end
    end

    // Error model and per-cycle port comparison
    int         err_m   = 0;
    bit         pend    = 1'b0;
    bit         mism    = 1'b0;
    logic [7:0] exp_b   = 8'h01;
    int         wr_lows = 0;
    logic [2:0] prev_addr = 3'b010;

    always @(negedge clk) begin
        if (!rst_n) begin
            err_m = 0; pend = 1'b0; exp_b = 8'h01; prev_addr = 3'b010;
        end else begin
            if (pend) begin
                if (mism && err_m < 15) err_m++;
                pend = 1'b0;
            end
            chk(ready == rdy_m, "R3/R4/R5 ready timing", ready, rdy_m);
            chk(err_cnt == err_m, "R8/R9 error count", err_cnt, err_m);
            chk(bus_rd == 1'b0, "R10 read strobe", bus_rd, 0);
            if (!bus_wr_n) begin
                wr_lows++;
                chk(bus_addr == 3'b010, "R2 write address", bus_addr, 3'b010);
                chk(bus_wdata == DW'(B + int'(div_lsb)), "R2 divisor value",
                    bus_wdata, B + int'(div_lsb));
            end
            if (ready) begin
                chk(bus_addr == 3'b001 || bus_addr == 3'b100, "R6 poll address", bus_addr, 1);
                chk(!(bus_addr == 3'b100 && prev_addr == 3'b100), "R6 single fetch cycle",
                    bus_addr, 3'b001);
                if (bus_addr == 3'b100) begin
                    pend  = 1'b1;
                    mism  = (bus_rdata != exp_b);
                    exp_b = next8(exp_b);
                end
            end
            prev_addr = bus_addr;
        end
    end

    logic [7:0] tx_b = 8'h01;

    task automatic send(input logic [7:0] flip);
        while (have || push_req) @(negedge clk);
        push_data = tx_b ^ flip;
        push_req  = 1'b1;
        @(negedge clk);
        push_req  = 1'b0;
        tx_b      = next8(tx_b);
    endtask

    task automatic drain();
        while (have) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        // Phase A: divisor low part 5, window 168 clocks, with glitches
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1 reset ready", ready, 0);
        chk(err_cnt == '0, "R1 reset error count", err_cnt, 0);
        chk(bus_wr_n == 1'b1, "R1 reset write strobe", bus_wr_n, 1);
        chk(bus_addr == 3'b010, "R1 reset address", bus_addr, 3'b010);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        rx_line = 1'b0;                       // R4: early glitch
        @(negedge clk);
        rx_line = 1'b1;
        repeat (150) @(negedge clk);
        chk(ready == 1'b0, "R4 ready held off after glitch", ready, 0);
        rx_line = 1'b0;                       // R4: late glitch
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        while (!ready) @(negedge clk);
        chk(wr_lows == 1, "R2 single divisor write", wr_lows, 1);

        // R5: line activity after alignment is ignored
        rx_line = 1'b0;
        repeat (5) @(negedge clk);
        rx_line = 1'b1;
        chk(ready == 1'b1, "R5 ready kept", ready, 1);

        // R7/R8: clean stream starting at 0x01
        for (int i = 0; i < 6; i++) send(8'h00);
        drain();
        chk(err_cnt == 4'd0, "R7/R8 clean stream", err_cnt, 0);

        // R8: three corrupted bytes
        for (int i = 0; i < 3; i++) send(8'h10);
        drain();
        chk(err_cnt == 4'd3, "R8 three mismatches", err_cnt, 3);

        // R9: drive through saturation
        for (int i = 0; i < 15; i++) send(8'h81);
        drain();
        chk(err_cnt == 4'd15, "R9 saturated", err_cnt, 15);
        for (int i = 0; i < 4; i++) send(8'h00);
        drain();
        chk(err_cnt == 4'd15, "R9 holds after clean bytes", err_cnt, 15);
        chk(wr_lows == 1, "R2 no further writes", wr_lows, 1);

        // Phase B: new reset, divisor low part 2, steady idle line
        rst_n   = 1'b0;
        div_lsb = 3'd2;
        wr_lows = 0;
        tx_b    = 8'h01;
        repeat (2) @(negedge clk);
        chk(err_cnt == '0, "R1 error count cleared", err_cnt, 0);
        chk(ready == 1'b0, "R1 ready cleared", ready, 0);
        rst_n = 1'b1;
        begin
            int k;
            k = 0;
            while (!ready) begin
                @(negedge clk);
                k++;
            end
            chk(k == (B + 2) * 8 + 2, "R3 alignment latency", k, (B + 2) * 8 + 2);
        end
        chk(wr_lows == 1, "R2 divisor written after reset", wr_lows, 1);
        send(8'h00);
        send(8'h04);
        send(8'h00);
        drain();
        chk(err_cnt == 4'd1, "R7/R8 one mismatch after reseed", err_cnt, 1);

        summary();
        $finish;
    end

endmodule